// File: doc/BRIEF.md
# Two-Road Crossing Light Controller

This block runs the signals at a crossing of a north-south road and an east-west road. Each road shows either green or red. Exactly one road is green at any moment, so the crossing is never all red and never all green. A car detector on each road says whether a car is waiting there. The controller keeps the current road green until a car waits on the other road. It then hands the green across.

Decisions are not made on every clock. An internal divider produces an update strobe once every `TICKS_PER_UPDATE` clocks, which is meant to be a slow interval of about half a minute on silicon and a few clocks in simulation. The lights may change only at the clock edge where that strobe is high. The detector inputs are asynchronous, so each one passes through a synchroniser of `SYNC_STAGES` flops before the decision logic uses it. A synchronous active-high reset starts the crossing with north-south green and restarts the interval.

Top module: `tlc_crossing`

## Requirements
- R1: At any clock edge where `rst` is 1, the block is forced to north-south green (`ns_green`=1, `ew_green`=0). The synchroniser flops are cleared to 0.
- R2: `ns_green` and `ew_green` are always complements of each other.
- R3: At an update edge with north-south green, a synchronised east-west detector of 1 switches to east-west green. The north-south detector has no effect in this case.
- R4: At an update edge with east-west green, a synchronised north-south detector of 1 switches to north-south green. The east-west detector has no effect in this case.
- R5: At an update edge where the detector of the red road reads 0, the green stays on the same road.
- R6: Update edges are the edges numbered k·`TICKS_PER_UPDATE` (k = 1, 2, ...), counted from the first edge after `rst` falls. The lights never change at any other edge.
- R7: With the default `SYNC_STAGES`=2, the decision at update edge U uses the detector level that was sampled at edge U-2. A level that first appears at edge U-1 is not seen until the following update.
- R8: Reset restarts the interval. The first update after release happens exactly `TICKS_PER_UPDATE` edges after the release, no matter where the interval stood when reset was asserted.
- R9: A detector level that is present only between updates, and has gone before it is sampled for an update, has no effect on the lights.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| car_ns | input | 1 | Asynchronous car detector on the north-south road, 1 = car waiting |
| car_ew | input | 1 | Asynchronous car detector on the east-west road, 1 = car waiting |
| ns_green | output | 1 | Registered, 1 = north-south green (east-west red) |
| ew_green | output | 1 | Registered, 1 = east-west green (north-south red) |

## Verification
The bench runs a short interval and sweeps every detector pattern from both green states. A design that gives the green back on its own, or that looks at the wrong road's detector, is caught because its lights differ from the expected road right after the update. A detector is raised exactly one and exactly two edges ahead of an update. This catches a synchroniser that is too short, too long or bypassed, because that design switches one interval early or late. A car that leaves before it is sampled, and a reset in mid-interval, check that no change is ever taken between updates and that the interval restarts. A counter that is not cleared by reset would switch at the wrong edge.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

    // Which road currently holds the green; the other road is red.
    typedef enum logic {
        GRN_NS = 1'b0,
        GRN_EW = 1'b1
    } road_e;

    // Synchronised detector pair handed to the phase machine.
    typedef struct packed {
        logic car_ns;
        logic car_ew;
    } det_t;

endpackage

// File: rtl/tlc_update_timer.sv
module tlc_update_timer #(
    parameter int unsigned TICKS_PER_UPDATE = 32'd1_500_000_000
) (
    input  logic clk,
    input  logic rst,
    output logic upd_tick
);

    localparam int unsigned CNT_W = (TICKS_PER_UPDATE > 1) ? $clog2(TICKS_PER_UPDATE) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_UPDATE - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d    = tmr_q;
        upd_tick = (tmr_q.cnt == LAST);
        if (upd_tick) begin
            tmr_d.cnt = '0;
        end else begin
            tmr_d.cnt = tmr_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

endmodule

// File: rtl/tlc_sync.sv
module tlc_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [STAGES-1:0][WIDTH-1:0] stg_d, stg_q;

    // The first stage samples the raw input; each later stage copies the one before it.
    always_comb begin
        stg_d[0] = async_in;
        for (int i = 1; i < int'(STAGES); i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_q <= '0;
        end else begin
            stg_q <= stg_d;
        end
    end

    assign sync_out = stg_q[STAGES-1];

endmodule

// File: rtl/tlc_phase_fsm.sv
module tlc_phase_fsm
    import tlc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  upd_tick,
    input  det_t  det,
    output road_e green_road
);

    typedef struct packed {
        road_e road;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    // The green moves only on an update, and only towards a road with a waiting car.
    always_comb begin
        fsm_d = fsm_q;
        if (upd_tick) begin
            unique case (fsm_q.road)
                GRN_NS: if (det.car_ew) fsm_d.road = GRN_EW;
                GRN_EW: if (det.car_ns) fsm_d.road = GRN_NS;
                default: fsm_d.road = GRN_NS;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm_q.road <= GRN_NS;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign green_road = fsm_q.road;

endmodule

// File: rtl/tlc_crossing.sv
module tlc_crossing
    import tlc_pkg::*;
#(
    parameter int unsigned TICKS_PER_UPDATE = 32'd1_500_000_000,
    parameter int unsigned SYNC_STAGES      = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic car_ns,
    input  logic car_ew,
    output logic ns_green,
    output logic ew_green
);

    logic       upd_tick;
    logic [1:0] det_raw;
    logic [1:0] det_sync;
    det_t       det;
    road_e      green_road;
    logic       det_ns;
    logic       det_ew;

    assign det_raw = {car_ns, car_ew};

    tlc_update_timer #(
        .TICKS_PER_UPDATE (TICKS_PER_UPDATE)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .upd_tick (upd_tick)
    );

    tlc_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (det_raw),
        .sync_out (det_sync)
    );

    assign det_ns     = det_sync[1];
    assign det_ew     = det_sync[0];
    assign det.car_ns = det_ns;
    assign det.car_ew = det_ew;

    tlc_phase_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .upd_tick   (upd_tick),
        .det        (det),
        .green_road (green_road)
    );

    // Both lamps are decoded from the single state flop, so they cannot both be on or both be off.
    assign ns_green = (green_road == GRN_NS);
    assign ew_green = (green_road == GRN_EW);

endmodule

// File: rtl/tlc_crossing_chk.sv
module tlc_crossing_chk #(
    parameter int unsigned TICKS_PER_UPDATE = 32'd1_500_000_000
) (
    input logic clk,
    input logic rst,
    input logic upd_tick,
    input logic det_ns,
    input logic det_ew,
    input logic ns_green,
    input logic ew_green
);

    localparam int unsigned CNT_W = (TICKS_PER_UPDATE > 1) ? $clog2(TICKS_PER_UPDATE) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_UPDATE - 1);

    // Independent count of edges since the last update, used to check the strobe spacing.
    logic [CNT_W-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst || gap_q == LAST) begin
            gap_q <= '0;
        end else begin
            gap_q <= gap_q + CNT_W'(1);
        end
    end

    p_reset_ns_r1: assert property (@(posedge clk) rst |=> (ns_green && !ew_green));

    p_one_green_r2: assert property (@(posedge clk) disable iff (rst) ns_green != ew_green);

    p_to_ew_r3: assert property (@(posedge clk) disable iff (rst)
        (upd_tick && ns_green && det_ew) |=> ew_green);

    p_to_ns_r4: assert property (@(posedge clk) disable iff (rst)
        (upd_tick && ew_green && det_ns) |=> ns_green);

    p_stay_ns_r5: assert property (@(posedge clk) disable iff (rst)
        (upd_tick && ns_green && !det_ew) |=> ns_green);

    p_stay_ew_r5: assert property (@(posedge clk) disable iff (rst)
        (upd_tick && ew_green && !det_ns) |=> ew_green);

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !upd_tick |=> $stable(ns_green));

    p_tick_spacing_r8: assert property (@(posedge clk) disable iff (rst)
        upd_tick == (gap_q == LAST));

endmodule

bind tlc_crossing tlc_crossing_chk #(
    .TICKS_PER_UPDATE (TICKS_PER_UPDATE)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .upd_tick (upd_tick),
    .det_ns   (det_ns),
    .det_ew   (det_ew),
    .ns_green (ns_green),
    .ew_green (ew_green)
);

// File: tb/tlc_crossing_test.sv
`timescale 1ns/1ps
module tlc_crossing_test;

    localparam int N = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic car_ns = 1'b0;
    logic car_ew = 1'b0;
    logic ns_green;
    logic ew_green;

    int vectors = 0;
    int fails   = 0;
    int ecnt    = 0;
    bit done    = 1'b0;
    bit exp_ns  = 1'b1;

    // Reference built from the requirements: interval count, two-edge detector delay, road choice.
    int   mcnt = 0;
    logic ms1_ns = 1'b0, ms1_ew = 1'b0, ms2_ns = 1'b0, ms2_ew = 1'b0;
    logic mns = 1'b1;
    bit   mvalid = 1'b0;

    tlc_crossing #(.TICKS_PER_UPDATE(N), .SYNC_STAGES(2)) uut (
        .clk      (clk),
        .rst      (rst),
        .car_ns   (car_ns),
        .car_ew   (car_ew),
        .ns_green (ns_green),
        .ew_green (ew_green)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (rst) ecnt <= 0;
        else     ecnt <= ecnt + 1;
    end

    always @(posedge clk) begin
        mvalid <= 1'b1;
        if (rst) begin
            mcnt <= 0; mns <= 1'b1;
            ms1_ns <= 1'b0; ms1_ew <= 1'b0; ms2_ns <= 1'b0; ms2_ew <= 1'b0;
        end else begin
            ms1_ns <= car_ns; ms1_ew <= car_ew;
            ms2_ns <= ms1_ns; ms2_ew <= ms1_ew;
            mcnt   <= (mcnt == N - 1) ? 0 : mcnt + 1;
            if (mcnt == N - 1) begin
                if (mns && ms2_ew)       mns <= 1'b0;
                else if (!mns && ms2_ns) mns <= 1'b1;
            end
        end
    end

    // Every cycle: lights against the reference, and the complement rule.
    always @(negedge clk) begin
        if (mvalid && !done) begin
            vectors++;
            if (ns_green !== mns) begin
                fails++;
                $display("FAIL R6 cycle compare at edge %0d: ns_green=%0b expected %0b", ecnt, ns_green, mns);
            end
            vectors++;
            if (ew_green !== ~ns_green) begin
                fails++;
                $display("FAIL R2 complement: ns_green=%0b ew_green=%0b expected ew_green=%0b",
                         ns_green, ew_green, ~ns_green);
            end
        end
    end

    task automatic chk(input string req, input bit exp);
        vectors++;
        if (ns_green !== exp || ew_green !== ~exp) begin
            fails++;
            $display("FAIL %s at edge %0d: ns_green=%0b ew_green=%0b expected ns_green=%0b ew_green=%0b",
                     req, ecnt, ns_green, ew_green, exp, ~exp);
        end
    endtask

    task automatic wait_ecnt(input int k);
        while (ecnt != k) @(negedge clk);
    endtask

    task automatic align();
        @(negedge clk);
        while (ecnt % N != 0) @(negedge clk);
    endtask

    // Holds one detector pattern for a whole interval and checks both sides of the update.
    task automatic apply_interval(input bit ns, input bit ew, input string req);
        int u;
        u = ecnt + N;
        car_ns = ns; car_ew = ew;
        wait_ecnt(u - 1);
        chk("R6 hold before update", exp_ns);
        wait_ecnt(u);
        if (exp_ns && ew)       exp_ns = 1'b0;
        else if (!exp_ns && ns) exp_ns = 1'b1;
        chk(req, exp_ns);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired: actual hung expected finish");
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        int u;
        logic [1:0] combo;
        repeat (3) @(negedge clk);
        chk("R1 reset state", 1'b1);
        rst = 1'b0;

        // Sweep all detector pairs from both green states.
        align();
        for (int i = 0; i < 32; i++) begin
            combo = 2'((i ^ (i >> 2)) & 3);
            if (exp_ns) apply_interval(combo[1], combo[0], combo[0] ? "R3 switch to EW" : "R5 stay NS");
            else        apply_interval(combo[1], combo[0], combo[1] ? "R4 switch to NS" : "R5 stay EW");
        end

        // Bring the crossing to NS green.
        if (!exp_ns) apply_interval(1'b1, 1'b0, "R4 switch to NS");

        // R7: detector raised one edge too late is seen only at the next update.
        car_ns = 1'b0; car_ew = 1'b0;
        u = ecnt + N;
        wait_ecnt(u - 2);
        car_ew = 1'b1;
        wait_ecnt(u);
        chk("R7 late detector ignored", 1'b1);
        wait_ecnt(u + N);
        exp_ns = 1'b0;
        chk("R7 late detector taken next update", 1'b0);

        // R7: detector raised in time is taken at this update.
        car_ns = 1'b0; car_ew = 1'b0;
        u = ecnt + N;
        wait_ecnt(u - 3);
        car_ns = 1'b1;
        wait_ecnt(u);
        exp_ns = 1'b1;
        chk("R7 timely detector taken", 1'b1);

        // R9: a car that leaves before sampling changes nothing.
        car_ns = 1'b0; car_ew = 1'b1;
        u = ecnt + N;
        wait_ecnt(u - 3);
        car_ew = 1'b0;
        wait_ecnt(u - 1);
        chk("R9 no change mid interval", 1'b1);
        wait_ecnt(u);
        chk("R9 departed car ignored", 1'b1);

        // Go to EW green, then reset in mid-interval.
        apply_interval(1'b0, 1'b1, "R3 switch to EW");
        car_ew = 1'b0; car_ns = 1'b0;
        wait_ecnt(ecnt + 3);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        exp_ns = 1'b1;
        chk("R1 reset from EW", 1'b1);
        car_ew = 1'b1;
        rst = 1'b0;
        @(negedge clk);
        wait_ecnt(N - 1);
        chk("R8 no update before full interval", 1'b1);
        wait_ecnt(N);
        exp_ns = 1'b0;
        chk("R8 first update after release", 1'b0);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule